// File: doc/BRIEF.md
# Serial SAR Conversion Controller

This block is the digital sequencer of a successive-approximation converter with a three-wire serial port. It runs on a fast system clock and treats the serial bit clock as a one-cycle enable, `sclk_tick`, asserted once per serial clock rising edge. A rising edge on the conversion strobe arms a conversion. At the next qualifying serial tick the approximation register is cleared to a mid-scale trial, and the block makes one bit decision per tick, most significant bit first. Each decision comes from an external comparator that compares the held input against the trial code the block drives to the DAC.

The serial pin carries a thirteen-bit frame. The first bit is a reference-ready status bit, followed by data bits D11 down to D0. Outside the frame the pin driver is disabled. All outputs change only on serial ticks, so a receiver can capture each bit on the following rising serial edge. A sample/hold control output shows when the input is held. A one-cycle done pulse marks the tick that drives D0.

A strobe that rises too close to a serial tick misses it, and the whole frame then starts one tick later. A conversion in progress cannot be restarted. Results are straight binary in unipolar mode and two's complement in bipolar mode.

Top module: `sar_serial_ctrl`

## Requirements
- R1: A rising edge on `conv_i` while no conversion is running arms a conversion. At its start tick `trial_code_o` becomes 0x800 (only bit 11 set) and `hold_o` rises to 1.
- R2: Rising edges on `conv_i` from the start tick until the frame has ended are ignored. The frame in progress is unchanged, and no second frame follows.
- R3: On each of the 12 ticks after the start tick, one bit is decided, from bit 11 down to bit 0. A bit is kept as 1 when `cmp_i` is 1 (input code at or above the trial), and the next lower bit is then set to 1 as the new trial. After the last decision `trial_code_o` equals the input code.
- R4: `sdo_oe_o` is 1 for exactly 13 consecutive serial ticks, starting at the start tick. The first frame bit is `ref_ok_i` as sampled at the start tick, followed by D11 down to D0. At all other times `sdo_oe_o` is 0.
- R5: `sdo_o`, `sdo_oe_o` and `hold_o` change only on clock edges at which `sclk_tick` is 1.
- R6: If the strobe edge is seen at least SETUP_CYC (default 4) clock cycles before a tick, that tick is the start tick. Otherwise the start tick is the tick after it, which delays the frame by one tick.
- R7: With `bipolar_i` = 0 at the start tick, the data bits are the straight binary code. With `bipolar_i` = 1, the data bits are the two's complement code, which is the binary code with D11 inverted. `trial_code_o` stays straight binary in both modes.
- R8: `hold_o` is 1 from the start tick through the tick that decides bit 1, and returns to 0 on the tick that decides bit 0.
- R9: `done_o` is a single-cycle pulse in the clock cycle after the tick that drives D0.
- R10: During reset (`rst` = 1), `sdo_o`, `sdo_oe_o`, `hold_o`, `done_o` and `trial_code_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_tick | input | 1 | One-cycle enable marking each serial clock rising edge |
| conv_i | input | 1 | Conversion strobe; a rising edge starts a conversion |
| bipolar_i | input | 1 | 1 selects two's complement output, 0 straight binary |
| ref_ok_i | input | 1 | Reference-ready status, sent as the first frame bit |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial code |
| trial_code_o | output | NBITS | Trial code driven to the DAC |
| hold_o | output | 1 | Sample/hold control, 1 = hold |
| sdo_o | output | 1 | Serial data pin value |
| sdo_oe_o | output | 1 | Serial pin driver enable; 0 = high impedance |
| done_o | output | 1 | Pulse after D0 has been driven |

## Verification
The assertions assume that `sclk_tick` is a single-cycle pulse with ticks spaced more than SETUP_CYC cycles apart. They also assume that `cmp_i` settles to a function of the current trial code within one clock, and that reset is held from time zero. The stimulus holds the tick period at eight system cycles and derives the comparator as an ideal combinational compare against the stimulus code. It changes the strobe, mode and status inputs only on falling clock edges. The strobe is placed at chosen offsets before a tick, including the offset on each side of the setup boundary and the offset where the strobe edge and the tick fall in the same cycle.

// File: rtl/sar_serial_pkg.sv
`timescale 1ns/1ps
package sar_serial_pkg;
  // strobe qualification states
  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_WAIT = 2'd1,
    ARM_LATE = 2'd2
  } arm_state_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sar_serial_arm.sv
`timescale 1ns/1ps
module sar_serial_arm #(
  parameter int SETUP_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic conv_i,
  input  logic busy_i,
  output logic start_o
);
  import sar_serial_pkg::*;
  localparam int CW = $clog2(SETUP_CYC + 1);
  localparam logic [CW-1:0] SETUP_V = CW'(SETUP_CYC);

  arm_state_t     st;
  logic           conv_q;
  logic [CW-1:0]  elapsed;
  logic           rise;

  assign rise = conv_i & ~conv_q;

  always_comb begin
    start_o = 1'b0;
    if (tick_i) begin
      if (st == ARM_LATE) start_o = 1'b1;
      else if (st == ARM_WAIT && elapsed >= SETUP_V) start_o = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_q  <= 1'b0;
      st      <= ARM_IDLE;
      elapsed <= '0;
    end else begin
      conv_q <= conv_i;
      case (st)
        ARM_IDLE: begin
          if (rise && !busy_i) begin
            if (tick_i) begin
              st <= ARM_LATE;
            end else begin
              st      <= ARM_WAIT;
              elapsed <= CW'(1);
            end
          end
        end
        ARM_WAIT: begin
          if (tick_i) begin
            st <= (elapsed >= SETUP_V) ? ARM_IDLE : ARM_LATE;
          end else if (elapsed < SETUP_V) begin
            elapsed <= elapsed + CW'(1);
          end
        end
        ARM_LATE: begin
          if (tick_i) st <= ARM_IDLE;
        end
        default: st <= ARM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_serial_seq.sv
`timescale 1ns/1ps
module sar_serial_seq #(
  parameter int NBITS = 12
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       tick_i,
  input  logic                                       start_i,
  output logic                                       busy_o,
  output logic                                       dec_en_o,
  output logic [sar_serial_pkg::idx_width(NBITS)-1:0] dec_idx_o,
  output logic                                       fin_o
);
  localparam int PW = $clog2(NBITS + 1);
  localparam int IW = sar_serial_pkg::idx_width(NBITS);

  logic [PW-1:0] ph;
  logic [PW-1:0] rem;

  assign rem       = PW'(NBITS - 1) - ph;
  assign dec_idx_o = rem[IW-1:0];
  assign dec_en_o  = busy_o && tick_i && (ph < PW'(NBITS));
  assign fin_o     = busy_o && tick_i && (ph == PW'(NBITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      ph     <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      ph     <= '0;
    end else if (busy_o && tick_i) begin
      if (ph == PW'(NBITS)) busy_o <= 1'b0;
      else                  ph     <= ph + PW'(1);
    end
  end
endmodule

// File: rtl/sar_serial_reg.sv
`timescale 1ns/1ps
module sar_serial_reg #(
  parameter int NBITS = 12
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       start_i,
  input  logic                                       dec_en_i,
  input  logic [sar_serial_pkg::idx_width(NBITS)-1:0] dec_idx_i,
  input  logic                                       cmp_i,
  output logic [NBITS-1:0]                           q_o
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        bit_q <= 1'b0;
      end else if (start_i) begin
        bit_q <= (i == NBITS - 1);
      end else if (dec_en_i) begin
        if (int'(dec_idx_i) == i)          bit_q <= cmp_i;
        else if (int'(dec_idx_i) == i + 1) bit_q <= 1'b1;
      end
    end
    assign q_o[i] = bit_q;
  end
endmodule

// File: rtl/sar_serial_ctrl.sv
`timescale 1ns/1ps
module sar_serial_ctrl #(
  parameter int NBITS     = 12,
  parameter int SETUP_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_tick,
  input  logic             conv_i,
  input  logic             bipolar_i,
  input  logic             ref_ok_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] trial_code_o,
  output logic             hold_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             done_o
);
  localparam int IW = sar_serial_pkg::idx_width(NBITS);

  logic          start;
  logic          busy;
  logic          dec_en;
  logic          fin;
  logic [IW-1:0] dec_idx;
  logic          bip_l;
  logic          msb_dec;

  sar_serial_arm #(.SETUP_CYC(SETUP_CYC)) u_arm (
    .clk(clk), .rst(rst), .tick_i(sclk_tick), .conv_i(conv_i),
    .busy_i(busy), .start_o(start)
  );

  sar_serial_seq #(.NBITS(NBITS)) u_seq (
    .clk(clk), .rst(rst), .tick_i(sclk_tick), .start_i(start),
    .busy_o(busy), .dec_en_o(dec_en), .dec_idx_o(dec_idx), .fin_o(fin)
  );

  sar_serial_reg #(.NBITS(NBITS)) u_reg (
    .clk(clk), .rst(rst), .start_i(start), .dec_en_i(dec_en),
    .dec_idx_i(dec_idx), .cmp_i(cmp_i), .q_o(trial_code_o)
  );

  assign msb_dec = (int'(dec_idx) == NBITS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_o   <= 1'b0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
      done_o   <= 1'b0;
      bip_l    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start) begin
        hold_o   <= 1'b1;
        sdo_oe_o <= 1'b1;
        sdo_o    <= ref_ok_i;
        bip_l    <= bipolar_i;
      end else if (dec_en) begin
        sdo_o <= cmp_i ^ (bip_l & msb_dec);
        if (dec_idx == '0) begin
          hold_o <= 1'b0;
          done_o <= 1'b1;
        end
      end else if (fin) begin
        sdo_oe_o <= 1'b0;
        sdo_o    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sar_serial_chk.sv
`timescale 1ns/1ps
module sar_serial_chk #(
  parameter int NBITS = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [NBITS-1:0] trial_code,
  input logic             hold,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             done
);
  localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};
  localparam int LW = $clog2(NBITS + 2);

  logic [LW-1:0] len_cnt;

  always_ff @(posedge clk) begin
    if (rst || !sdo_oe) len_cnt <= '0;
    else if (tick)      len_cnt <= len_cnt + LW'(1);
  end

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> ($stable(sdo) && $stable(sdo_oe) && $stable(hold))); // R5
  AST_START_TRIAL: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> (trial_code == MSB_ONLY)); // R1
  AST_START_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $rose(sdo_oe)); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    ($past(sdo_oe) && sdo_oe) |-> !$rose(hold)); // R2
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> (len_cnt <= LW'(NBITS))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!hold && sdo_oe)); // R8
endmodule

bind sar_serial_ctrl sar_serial_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst(rst), .tick(sclk_tick), .trial_code(trial_code_o),
  .hold(hold_o), .sdo(sdo_o), .sdo_oe(sdo_oe_o), .done(done_o)
);

// File: tb/sim_sar_serial_ctrl.sv
`timescale 1ns/1ps
module sim_sar_serial_ctrl;
  logic clk = 1'b0;
  logic rst, tick, conv, bip, refok;
  logic [11:0] vin;
  logic cmp;
  logic [11:0] trial_code;
  logic hold, sdo, sdo_oe, done;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int tcnt, ticks_after, first_tick, nb, done_cnt, r5_bad;
  bit ended;
  logic [12:0] frame;
  logic [11:0] t0_code;
  logic holdv [0:12];
  logic donev [0:12];
  logic p_sdo, p_oe, p_hold;

  always #10 clk = ~clk;
  assign cmp = (vin >= trial_code);

  sar_serial_ctrl u0 (
    .clk(clk), .rst(rst), .sclk_tick(tick), .conv_i(conv), .bipolar_i(bip),
    .ref_ok_i(refok), .cmp_i(cmp), .trial_code_o(trial_code), .hold_o(hold),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one system cycle: sample outputs of the last edge, then drive inputs
  task automatic cyc(input logic c);
    @(negedge clk);
    if (!tick && (sdo !== p_sdo || sdo_oe !== p_oe || hold !== p_hold)) r5_bad++;
    if (tick) begin
      ticks_after++;
      if (sdo_oe) begin
        if (nb == 0) begin
          first_tick = ticks_after;
          t0_code = trial_code;
        end
        if (nb < 13) begin
          frame = {frame[11:0], sdo};
          holdv[nb] = hold;
          donev[nb] = done;
        end
        nb++;
      end else if (nb > 0) begin
        ended = 1;
      end
    end
    if (done) done_cnt++;
    p_sdo = sdo; p_oe = sdo_oe; p_hold = hold;
    tick = (tcnt == 7);
    tcnt = (tcnt + 1) % 8;
    conv = c;
  endtask

  task automatic run_conv(input string tag, input logic [11:0] v, input bit b,
                          input bit r, input int p, input int exp_first, input bit retrig);
    logic [11:0] exp_data;
    bit hold_ok;
    vin = v; bip = b; refok = r;
    while (tcnt != p) cyc(1'b0);
    ticks_after = 0; nb = 0; frame = '0; done_cnt = 0; ended = 0; r5_bad = 0;
    for (int i = 0; i < 13; i++) begin holdv[i] = 1'b0; donev[i] = 1'b0; end
    cyc(1'b1); cyc(1'b1); cyc(1'b1);
    for (int i = 0; i < 300 && !ended; i++) cyc(retrig && ticks_after == 5);
    repeat (48) cyc(1'b0);
    exp_data = b ? (v ^ 12'h800) : v;
    $display("scenario %s", tag);
    check(first_tick == exp_first, "R6 start tick", first_tick, exp_first);
    check(t0_code == 12'h800, "R1 initial trial", t0_code, 12'h800);
    check(nb == 13, retrig ? "R2 frame length with restart attempt" : "R4 frame length", nb, 13);
    check(frame[12] == r, "R4 status bit", frame[12], r);
    check(frame[11:0] == exp_data, b ? "R7 bipolar data" : "R3 unipolar data", frame[11:0], exp_data);
    check(trial_code == v, "R3 final trial code", trial_code, v);
    hold_ok = 1;
    for (int i = 0; i < 12; i++) if (holdv[i] !== 1'b1) hold_ok = 0;
    check(hold_ok && holdv[12] === 1'b0, "R8 hold pattern", {hold_ok, holdv[12]}, 2);
    check(done_cnt == 1 && donev[12] === 1'b1, "R9 done pulse", done_cnt, 1);
    check(sdo_oe == 1'b0, "R4 pin released", sdo_oe, 0);
    check(r5_bad == 0, "R5 changes only on tick", r5_bad, 0);
  endtask

  task automatic t_reset;
    rst = 1; tick = 0; conv = 0; bip = 0; refok = 0; vin = 0; tcnt = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    check(sdo_oe == 0 && sdo == 0 && hold == 0 && done == 0, "R10 reset outputs",
          {sdo_oe, sdo, hold, done}, 0);
    check(trial_code == 0, "R10 reset trial", trial_code, 0);
    p_sdo = sdo; p_oe = sdo_oe; p_hold = hold;
  endtask

  task automatic t_unipolar_early;  run_conv("unipolar early", 12'hA5C, 0, 1, 1, 1, 0); endtask
  task automatic t_bipolar;         run_conv("bipolar",        12'h123, 1, 0, 1, 1, 0); endtask
  task automatic t_late_fullscale;  run_conv("late full",      12'hFFF, 0, 1, 5, 2, 0); endtask
  task automatic t_setup_edge_ok;   run_conv("setup exact",    12'h000, 0, 1, 3, 1, 0); endtask
  task automatic t_setup_edge_late; run_conv("setup short",    12'h800, 1, 1, 4, 2, 0); endtask
  task automatic t_same_cycle;      run_conv("same cycle",     12'h001, 0, 0, 7, 2, 0); endtask
  task automatic t_restart_ignored; run_conv("restart R2",     12'h7FF, 0, 1, 1, 1, 1); endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_unipolar_early();
    t_bipolar();
    t_late_fullscale();
    t_setup_edge_ok();
    t_setup_edge_late();
    t_same_cycle();
    t_restart_ignored();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule